// File: doc/BRIEF.md
# Two-Layer Circuit-Switched Mesh Link Switch

This block is the routing switch that sits in one tile of a mesh of processing tiles. Each of the tile's four edges has two outgoing and two incoming links, one per layer, so there are eight input links and eight output links. Every link carries a data word, a valid strobe and a ready signal that flows back toward the sender. Each output link has a route field that picks its source: either the local core or the input of the same layer on one of the other three edges. A route, once set, forms a dedicated channel through the tile. Words can then cross many tiles without the intermediate cores taking any part.

The local core can send one word to any set of outputs in a cycle, chosen by a per-send mask. It also receives from two selectors, each of which can point at any of the eight input links. When one input feeds several receivers, it broadcasts. The ready returned to that input is the combined readiness of every receiver that is currently attached to it, so the word moves to all of them in the same cycle or to none. Any output can be given a registered hop to break a long route across several tiles. This hop is a two-entry stage that keeps one word per cycle of throughput.

A single clock is used throughout.

Top module: `mesh_link_switch`

## Requirements
- R1: Link index `i` = layer*4 + edge, with edge codes N=0, E=1, S=2, W=3 and layers 0 and 1. The data of link `i` occupies bits [DW*i +: DW] of the data vectors.
- R2: `cfg_route[2*o +: 2]` names the source edge of output `o`, always within the same layer as `o`. When the value equals output `o`'s own edge, the source is the core instead. A layer-0 input never reaches a layer-1 output, and a layer-1 input never reaches a layer-0 output.
- R3: A word transfers on an input link in a cycle exactly when `in_valid` and `in_ready` are both high. On a bypass output, `out_valid` and `out_data` then show that word in the same cycle.
- R4: `in_ready[j]` is the AND over every receiver attached to input `j` of that receiver's ready, where a receiver that is not attached does not count. If no receiver is attached, `in_ready[j]` is 1.
- R5: A word broadcast from one input appears on all attached outputs and selectors in the same cycle. If any attached receiver is not ready, the word appears on none of them.
- R6: The core drives output `o` only when `o` routes from the core and `core_mask[o]` is 1. `core_ready` is the AND of the readiness of those outputs. A zero mask drives no output and gives `core_ready` = 1.
- R7: `cfg_rx0_sel` and `cfg_rx1_sel` (3-bit link indices) select an input link for each core selector. `rxN_valid` is high exactly when that link transfers, and `rxN_data` equals that link's data.
- R8: When `cfg_pipe[o]` is 1, output `o` has a registered hop. A word accepted in one cycle is offered from the next cycle. The hop holds up to two words, reports ready while not full, keeps words in order, loses none, and holds `out_valid` and `out_data` steady while stalled. `cfg_pipe` changes only when the hops are empty.
- R9: A registered hop whose downstream is always ready passes one word every cycle.
- R10: During and right after reset, every registered hop is empty, so pipelined outputs show `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8*DW | Data of the eight input links |
| in_valid | input | 8 | Valid of each input link |
| in_ready | output | 8 | Combined ready returned on each input link |
| out_data | output | 8*DW | Data of the eight output links |
| out_valid | output | 8 | Valid of each output link |
| out_ready | input | 8 | Ready from the downstream receiver of each output link |
| cfg_route | input | 16 | 2-bit source edge per output link |
| cfg_pipe | input | 8 | Registered-hop enable per output link |
| cfg_rx0_sel | input | 3 | Input link index for core selector 0 |
| cfg_rx1_sel | input | 3 | Input link index for core selector 1 |
| core_data | input | DW | Word the core sends |
| core_valid | input | 1 | Core send request |
| core_mask | input | 8 | Output links the core targets on this send |
| core_ready | output | 1 | All targeted outputs can accept |
| rx0_data | output | DW | Data seen by core selector 0 |
| rx0_valid | output | 1 | Transfer into core selector 0 |
| rx0_ready | input | 1 | Core selector 0 can accept |
| rx1_data | output | DW | Data seen by core selector 1 |
| rx1_valid | output | 1 | Transfer into core selector 1 |
| rx1_ready | input | 1 | Core selector 1 can accept |

## Verification
The switch is exercised under four route patterns.
- A crossing pattern mixes turns, straight paths and core sources in both layers. A wrong index or a layer leak shows up there as data on the wrong output.
- A broadcast pattern feeds three outputs and a core selector from one input while their readies toggle on their own. This separates a correct all-or-none transfer from one where a single receiver runs ahead.
- A core-only pattern with random masks, including zero masks, tests mask gating and the core's ready.
- The crossing pattern is repeated with the registered hops switched on, first with random backpressure and then with a steady stream. This shows added latency, two-entry capacity, order and full rate.

// File: rtl/mls_pkg.sv
package mls_pkg;
  localparam int EDGES  = 4;
  localparam int LAYERS = 2;
  localparam int LINKS  = EDGES * LAYERS;
  localparam int SELW   = $clog2(LINKS);
  localparam int RTW    = $clog2(EDGES);

  // Link index of a given layer and edge (R1)
  function automatic logic [SELW-1:0] link_of(input int layer, input logic [RTW-1:0] edge_code);
    link_of = SELW'(layer * EDGES) + SELW'(edge_code);
  endfunction

  // An output routes from the core when its route names its own edge (R2)
  function automatic logic is_core_route(input logic [RTW-1:0] route, input int own_edge);
    is_core_route = (route == RTW'(own_edge));
  endfunction
endpackage

// File: rtl/mls_req_merge.sv
module mls_req_merge #(
  parameter int N = 8
) (
  input  logic [N-1:0] attach,
  input  logic [N-1:0] rdy,
  output logic         all_rdy
);
  // A detached receiver is treated as ready (R4)
  logic [N-1:0] masked;
  assign masked  = rdy | ~attach;
  assign all_rdy = &masked;
endmodule

// File: rtl/mls_hop_stage.sv
module mls_hop_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  logic [DW-1:0] slot [2];
  logic          wr_ptr, rd_ptr;
  logic [1:0]    count;
  logic          full, empty, push, pop;

  assign full  = (count == 2'd2);
  assign empty = (count == 2'd0);
  assign push  = pipe_en && in_valid && !full;
  assign pop   = pipe_en && !empty && out_ready;

  assign in_ready  = pipe_en ? !full    : out_ready;
  assign out_valid = pipe_en ? !empty   : in_valid;
  assign out_data  = pipe_en ? slot[rd_ptr] : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
      count  <= 2'd0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= in_data;
        wr_ptr       <= ~wr_ptr;
      end
      if (pop) rd_ptr <= ~rd_ptr;
      count <= count + {1'b0, push} - {1'b0, pop};
    end
  end
endmodule

// File: rtl/mesh_link_switch.sv
module mesh_link_switch #(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [mls_pkg::LINKS*DW-1:0] in_data,
  input  logic [mls_pkg::LINKS-1:0] in_valid,
  output logic [mls_pkg::LINKS-1:0] in_ready,
  output logic [mls_pkg::LINKS*DW-1:0] out_data,
  output logic [mls_pkg::LINKS-1:0] out_valid,
  input  logic [mls_pkg::LINKS-1:0] out_ready,
  input  logic [mls_pkg::LINKS*mls_pkg::RTW-1:0] cfg_route,
  input  logic [mls_pkg::LINKS-1:0] cfg_pipe,
  input  logic [mls_pkg::SELW-1:0]  cfg_rx0_sel,
  input  logic [mls_pkg::SELW-1:0]  cfg_rx1_sel,
  input  logic [DW-1:0]             core_data,
  input  logic                      core_valid,
  input  logic [mls_pkg::LINKS-1:0] core_mask,
  output logic                      core_ready,
  output logic [DW-1:0]             rx0_data,
  output logic                      rx0_valid,
  input  logic                      rx0_ready,
  output logic [DW-1:0]             rx1_data,
  output logic                      rx1_valid,
  input  logic                      rx1_ready
);
  import mls_pkg::*;

  localparam int NRCV = LINKS + 2;

  logic [LINKS-1:0]   from_core;
  logic [SELW-1:0]    src_idx [LINKS];
  logic [LINKS-1:0]   stage_vin;
  logic [DW-1:0]      stage_din [LINKS];
  logic [LINKS-1:0]   stage_rdy;
  logic [LINKS-1:0]   in_fire;
  logic               core_fire;
  logic [LINKS-1:0]   core_attach;
  logic [NRCV-1:0]    rcv_rdy;

  assign in_fire   = in_valid & in_ready;
  assign core_fire = core_valid && core_ready;
  assign rcv_rdy   = {rx1_ready, rx0_ready, stage_rdy};

  // Output muxes and optional registered hops (R2, R3, R8)
  for (genvar o = 0; o < LINKS; o++) begin : g_out
    localparam int OE = o % EDGES;
    localparam int OL = o / EDGES;
    logic [RTW-1:0] route;
    assign route        = cfg_route[RTW*o +: RTW];
    assign from_core[o] = is_core_route(route, OE);
    assign src_idx[o]   = link_of(OL, route);
    assign stage_vin[o] = from_core[o] ? (core_fire && core_mask[o]) : in_fire[src_idx[o]];
    assign stage_din[o] = from_core[o] ? core_data : in_data[DW*src_idx[o] +: DW];

    mls_hop_stage #(.DW(DW)) u_hop (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_en   (cfg_pipe[o]),
      .in_valid  (stage_vin[o]),
      .in_data   (stage_din[o]),
      .in_ready  (stage_rdy[o]),
      .out_valid (out_valid[o]),
      .out_data  (out_data[DW*o +: DW]),
      .out_ready (out_ready[o])
    );
  end

  // Per-input ready aggregation over attached receivers (R4, R5)
  for (genvar j = 0; j < LINKS; j++) begin : g_in
    logic [NRCV-1:0] attach;
    always_comb begin
      for (int o = 0; o < LINKS; o++) begin
        attach[o] = !from_core[o] && (src_idx[o] == SELW'(j));
      end
      attach[LINKS]   = (cfg_rx0_sel == SELW'(j));
      attach[LINKS+1] = (cfg_rx1_sel == SELW'(j));
    end

    mls_req_merge #(.N(NRCV)) u_merge (
      .attach  (attach),
      .rdy     (rcv_rdy),
      .all_rdy (in_ready[j])
    );
  end

  // Core send: masked fan-out to core-routed outputs (R6)
  assign core_attach = from_core & core_mask;

  mls_req_merge #(.N(LINKS)) u_core_merge (
    .attach  (core_attach),
    .rdy     (stage_rdy),
    .all_rdy (core_ready)
  );

  // Core receive selectors (R7)
  assign rx0_valid = in_fire[cfg_rx0_sel];
  assign rx0_data  = in_data[DW*cfg_rx0_sel +: DW];
  assign rx1_valid = in_fire[cfg_rx1_sel];
  assign rx1_data  = in_data[DW*cfg_rx1_sel +: DW];
endmodule

// File: rtl/mesh_link_switch_chk.sv
module mesh_link_switch_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [8*DW-1:0] in_data,
  input logic [7:0]    in_valid,
  input logic [7:0]    in_ready,
  input logic [8*DW-1:0] out_data,
  input logic [7:0]    out_valid,
  input logic [7:0]    out_ready,
  input logic [15:0]   cfg_route,
  input logic [7:0]    cfg_pipe,
  input logic [2:0]    cfg_rx0_sel,
  input logic [2:0]    cfg_rx1_sel,
  input logic          core_valid,
  input logic [7:0]    core_mask,
  input logic          core_ready,
  input logic          rx0_valid,
  input logic          rx0_ready
);
  for (genvar o = 0; o < 8; o++) begin : g_o
    localparam int OE = o % 4;
    localparam int OL = o / 4;
    logic [1:0] rt;
    logic [2:0] src;
    logic       routed;
    assign rt     = cfg_route[2*o +: 2];
    assign src    = {1'(OL), rt};
    assign routed = (rt != 2'(OE));

    // R3: a bypass output is valid only when its source transfers
    a_r3_valid_from_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe[o] && routed && out_valid[o]) |-> (in_valid[src] && in_ready[src]));

    // R4: a source transfer implies each attached bypass receiver was ready
    a_r4_attached_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pipe[o] && routed && in_valid[src] && in_ready[src]) |-> out_ready[o]);

    // R8: a stalled hop keeps its word
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pipe[o] && out_valid[o] && !out_ready[o]) |=>
      (!cfg_pipe[o] || (out_valid[o] && $stable(out_data[DW*o +: DW]))));
  end

  // R6: an empty mask never blocks the core
  a_r6_zero_mask_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (core_valid && core_mask == 8'h00) |-> core_ready);

  // R7: selector 0 receives exactly when its link transfers
  a_r7_rx0_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    rx0_valid == (in_valid[cfg_rx0_sel] && in_ready[cfg_rx0_sel]));

  // R4: a transfer on selector 0's link implies selector 0 was ready
  a_r4_rx0_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[cfg_rx0_sel] && in_ready[cfg_rx0_sel]) |-> rx0_ready);
endmodule

bind mesh_link_switch mesh_link_switch_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_data     (in_data),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .cfg_route   (cfg_route),
  .cfg_pipe    (cfg_pipe),
  .cfg_rx0_sel (cfg_rx0_sel),
  .cfg_rx1_sel (cfg_rx1_sel),
  .core_valid  (core_valid),
  .core_mask   (core_mask),
  .core_ready  (core_ready),
  .rx0_valid   (rx0_valid),
  .rx0_ready   (rx0_ready)
);

// File: tb/mesh_link_switch_bench.sv
`timescale 1ns/1ps
module mesh_link_switch_bench;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [8*DW-1:0] in_data;
  logic [7:0]      in_valid, in_ready;
  logic [8*DW-1:0] out_data;
  logic [7:0]      out_valid, out_ready;
  logic [15:0]     cfg_route;
  logic [7:0]      cfg_pipe;
  logic [2:0]      cfg_rx0_sel, cfg_rx1_sel;
  logic [DW-1:0]   core_data;
  logic            core_valid;
  logic [7:0]      core_mask;
  logic            core_ready;
  logic [DW-1:0]   rx0_data, rx1_data;
  logic            rx0_valid, rx1_valid, rx0_ready, rx1_ready;

  always #2.5 clk = ~clk;

  mesh_link_switch #(.DW(DW)) u_mesh_link_switch (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Reference state: one queue per output for registered hops
  logic [DW-1:0] mq [8][$];
  logic [7:0]    e_vin;
  logic [DW-1:0] e_din [8];
  int            e_size [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mk_route(input int a0, a1, a2, a3, a4, a5, a6, a7);
    int s[8] = '{a0, a1, a2, a3, a4, a5, a6, a7};
    logic [15:0] r = '0;
    for (int o = 0; o < 8; o++) r[2*o +: 2] = 2'(s[o]);
    return r;
  endfunction

  // Compute expected outputs from the requirements and compare
  task automatic eval_compare(input string req);
    bit srdy [8];
    bit ecore [8];
    int esrc [8];
    logic [7:0] e_inr, e_ov;
    bit e_cr;
    int rt;
    for (int o = 0; o < 8; o++) begin
      rt       = int'(cfg_route[2*o +: 2]);
      ecore[o] = (rt == o % 4);
      esrc[o]  = (o / 4) * 4 + rt;
      e_size[o] = mq[o].size();
      srdy[o]  = cfg_pipe[o] ? (e_size[o] < 2) : out_ready[o];
    end
    for (int j = 0; j < 8; j++) begin
      e_inr[j] = 1'b1;
      for (int o = 0; o < 8; o++)
        if (!ecore[o] && esrc[o] == j && !srdy[o]) e_inr[j] = 1'b0;
      if (int'(cfg_rx0_sel) == j && !rx0_ready) e_inr[j] = 1'b0;
      if (int'(cfg_rx1_sel) == j && !rx1_ready) e_inr[j] = 1'b0;
    end
    e_cr = 1'b1;
    for (int o = 0; o < 8; o++)
      if (ecore[o] && core_mask[o] && !srdy[o]) e_cr = 1'b0;
    for (int o = 0; o < 8; o++) begin
      if (ecore[o]) begin
        e_vin[o] = core_valid && e_cr && core_mask[o];
        e_din[o] = core_data;
      end else begin
        e_vin[o] = in_valid[esrc[o]] && e_inr[esrc[o]];
        e_din[o] = in_data[DW*esrc[o] +: DW];
      end
      e_ov[o] = cfg_pipe[o] ? (e_size[o] > 0) : e_vin[o];
    end
    chk(in_ready == e_inr, req, "in_ready", 128'(in_ready), 128'(e_inr));
    chk(core_ready == e_cr, req, "core_ready", 128'(core_ready), 128'(e_cr));
    chk(out_valid == e_ov, req, "out_valid", 128'(out_valid), 128'(e_ov));
    for (int o = 0; o < 8; o++) begin
      if (e_ov[o]) begin
        logic [DW-1:0] ed = cfg_pipe[o] ? mq[o][0] : e_din[o];
        if (out_data[DW*o +: DW] !== ed)
          chk(0, req, $sformatf("out_data[%0d]", o), 128'(out_data[DW*o +: DW]), 128'(ed));
      end
    end
    chk(rx0_valid == (in_valid[cfg_rx0_sel] && e_inr[cfg_rx0_sel]) &&
        rx1_valid == (in_valid[cfg_rx1_sel] && e_inr[cfg_rx1_sel]),
        {req, " R7"}, "rx valids", 128'({rx0_valid, rx1_valid}), 128'(0));
    if (rx0_valid && rx0_data !== in_data[DW*cfg_rx0_sel +: DW])
      chk(0, "R7", "rx0_data", 128'(rx0_data), 128'(in_data[DW*cfg_rx0_sel +: DW]));
    if (rx1_valid && rx1_data !== in_data[DW*cfg_rx1_sel +: DW])
      chk(0, "R7", "rx1_data", 128'(rx1_data), 128'(in_data[DW*cfg_rx1_sel +: DW]));
  endtask

  // Advance the reference at the clock edge
  task automatic model_update();
    for (int o = 0; o < 8; o++) begin
      if (cfg_pipe[o]) begin
        if (e_size[o] > 0 && out_ready[o]) void'(mq[o].pop_front());
        if (e_vin[o] && e_size[o] < 2) mq[o].push_back(e_din[o]);
      end
    end
  endtask

  task automatic cycle(input string req);
    #1;
    eval_compare(req);
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic run(input int n, input string req, input int vp, input int rp, input bit zmask);
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < 8; i++) begin
        in_valid[i]  = ($urandom % 100) < vp;
        out_ready[i] = ($urandom % 100) < rp;
        in_data[DW*i +: DW] = DW'($urandom);
      end
      core_valid = ($urandom % 100) < vp;
      core_data  = DW'($urandom);
      core_mask  = (zmask && (c % 4 == 0)) ? 8'h00 : 8'($urandom);
      rx0_ready  = ($urandom % 100) < rp;
      rx1_ready  = ($urandom % 100) < rp;
      cycle(req);
    end
  endtask

  task automatic drain(input string req);
    in_valid = '0; core_valid = 1'b0; out_ready = '1; rx0_ready = 1'b1; rx1_ready = 1'b1;
    for (int c = 0; c < 4; c++) cycle(req);
  endtask

  initial begin
    rst_n = 1'b0;
    in_data = '0; in_valid = '0; out_ready = '0;
    cfg_route = mk_route(0, 1, 2, 3, 0, 1, 2, 3);
    cfg_pipe = 8'hFF; cfg_rx0_sel = 3'd0; cfg_rx1_sel = 3'd1;
    core_data = '0; core_valid = 1'b0; core_mask = '0;
    rx0_ready = 1'b0; rx1_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R10: hops empty during reset
    chk(out_valid == 8'h00, "R10", "out_valid in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 8'h00, "R10", "out_valid after reset", 128'(out_valid), 128'(0));

    // R1 R2 R3: crossing routes in both layers, bypass
    cfg_pipe = 8'h00;
    cfg_route = mk_route(2, 3, 2, 1, 1, 1, 0, 2);
    cfg_rx0_sel = 3'd2; cfg_rx1_sel = 3'd5;
    run(300, "R1/R2/R3", 60, 70, 1'b0);

    // R2 layer isolation: only layer-0 W valid, layer-1 E routes from its own W
    cfg_route = mk_route(0, 3, 2, 3, 0, 3, 2, 3);
    in_valid = 8'h08; out_ready = '1; core_valid = 1'b0; rx0_ready = 1'b1; rx1_ready = 1'b1;
    in_data = '0; in_data[DW*3 +: DW] = 16'hA5A5;
    #1;
    chk(out_valid == 8'h02, "R2", "layer isolation valids", 128'(out_valid), 128'(8'h02));
    chk(out_data[DW*1 +: DW] == 16'hA5A5, "R1", "link 3 to link 1 data",
        128'(out_data[DW*1 +: DW]), 128'(16'hA5A5));
    @(negedge clk);

    // R4 R5: broadcast from layer-1 W to N, E, S and selector 0
    cfg_route = mk_route(0, 1, 2, 3, 3, 3, 3, 3);
    cfg_rx0_sel = 3'd7; cfg_rx1_sel = 3'd0;
    run(300, "R4/R5", 70, 75, 1'b0);
    // R5 directed: one attached receiver stalls, nothing moves
    in_valid = 8'h80; out_ready = 8'hDF; rx0_ready = 1'b1; core_valid = 1'b0;
    #1;
    chk(in_ready[7] == 1'b0, "R5", "in_ready[7] one stalled", 128'(in_ready[7]), 128'(0));
    chk((out_valid & 8'h70) == 8'h00 && !rx0_valid, "R5", "no partial broadcast",
        128'({rx0_valid, out_valid}), 128'(0));
    // R4 directed: stall on a core-fed output does not block the W input
    out_ready = 8'h7F;
    #1;
    chk(in_ready[7] == 1'b1, "R4", "detached stall ignored", 128'(in_ready[7]), 128'(1));
    @(negedge clk);

    // R6: all outputs from the core, random masks including zero
    cfg_route = mk_route(0, 1, 2, 3, 0, 1, 2, 3);
    cfg_rx0_sel = 3'd1; cfg_rx1_sel = 3'd6;
    run(300, "R6", 60, 60, 1'b1);
    core_valid = 1'b1; core_mask = 8'h00; out_ready = 8'h00; in_valid = '0;
    #1;
    chk(out_valid == 8'h00, "R6", "zero mask drives nothing", 128'(out_valid), 128'(0));
    chk(core_ready == 1'b1, "R6", "zero mask ready", 128'(core_ready), 128'(1));
    @(negedge clk);
    drain("R6");

    // R8: registered hops on every output with backpressure
    cfg_pipe = 8'hFF;
    cfg_route = mk_route(2, 3, 2, 1, 1, 1, 0, 2);
    cfg_rx0_sel = 3'd2; cfg_rx1_sel = 3'd5;
    run(400, "R8", 70, 50, 1'b0);
    drain("R8");
    cfg_pipe = 8'h5A;
    run(300, "R8", 70, 60, 1'b0);
    drain("R8");

    // R9: steady stream through the hop from link 3 to link 1
    begin
      int got = 0;
      cfg_pipe = 8'hFF;
      in_valid = 8'h08; out_ready = '1; rx0_ready = 1'b1; rx1_ready = 1'b1; core_valid = 1'b0;
      for (int c = 0; c < 20; c++) begin
        in_data[DW*3 +: DW] = DW'(c);
        #1;
        if (out_valid[1]) got++;
        eval_compare("R9");
        @(posedge clk);
        model_update();
        @(negedge clk);
      end
      chk(got == 19, "R9", "words in 20 cycles", 128'(got), 128'(19));
    end
    drain("R9");

    done = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule